// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Mode Register

This block is a full-duplex asynchronous serial transceiver. One side takes parallel bytes over a valid/ready handshake and shifts them out on a serial line. The other side samples an incoming serial line at sixteen times the bit rate and returns parallel bytes with a one-cycle valid strobe. It also reports a framing error flag, a parity error flag and a captured multiprocessor bit. A mode register sets the character format: the stop length, parity on or off and its sense, and multiprocessor mode. It also sets which prescaler tap feeds the baud generator. A separate 8-bit rate register sets the divider that turns the prescaled clock into the oversample tick.

The stop-length setting affects only the transmitter. The receiver samples just the first stop bit in every mode, so a line that drops low right after that bit begins the next character. When multiprocessor mode is on, the transmitter puts the caller's multiprocessor bit in the slot after the data bits. The receiver returns that bit on a flag and ignores the parity settings.

Top module: `serial_xcvr`

## Requirements
- R1: After reset the serial output is high, the transmitter is ready, the receive strobe and all three flags are low, the mode is one stop bit, no parity, multiprocessor off and prescaler tap 0, and the rate value is 0.
- R2: A transmitted character is one low start bit, then the 8 data bits least significant first, then an optional extra bit, then the stop bit(s), all high. A byte is taken only when tx_valid_i is high while tx_ready_o is high. When looped back, the same byte is received.
- R3: With mode bit 0 clear, one high stop bit ends each character. With mode bit 0 set, two high stop bits end it. Back-to-back characters therefore start 10 or 11 bit periods apart when there is no extra bit.
- R4: The receiver samples only the first stop bit. rx_frame_err_o is set with the receive strobe when that sample is low. The flags change only together with the one-cycle rx_valid_o strobe.
- R5: With two stop bits selected, a low level where the second stop bit would be is taken as the start of the next character, and no framing error is reported.
- R6: With mode bit 1 set and mode bit 3 clear, an extra parity bit is sent: even parity when mode bit 2 is clear (total ones including the parity bit even), odd parity when it is set. A received parity mismatch sets rx_par_err_o.
- R7: With mode bit 3 set, the extra bit carries tx_mpb_i whatever bits 1 and 2 hold. The received extra bit appears on rx_mpb_o, and rx_par_err_o stays low. rx_mpb_o is 0 when bit 3 is clear.
- R8: Mode bits 5:4 select the prescaler: 00 divide by 1, 01 by 4, 10 by 16, 11 by 64. With rate value N, one bit lasts 16*div*(N+1) clock cycles.
- R9: A falling edge on rx_i is confirmed as a start bit only if the line is still low 8 ticks later. A low pulse shorter than half a bit produces no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_we_i | input | 1 | Write strobe for the mode register |
| mode_wdata_i | input | 6 | Mode: [0] two stop, [1] parity on, [2] odd parity, [3] multiprocessor, [5:4] prescaler tap |
| rate_we_i | input | 1 | Write strobe for the rate register |
| rate_wdata_i | input | 8 | Rate divider value N |
| tx_data_i | input | 8 | Byte to transmit |
| tx_mpb_i | input | 1 | Multiprocessor bit to transmit |
| tx_valid_i | input | 1 | Transmit byte valid |
| tx_ready_o | output | 1 | Transmitter idle, can take a byte |
| tx_o | output | 1 | Serial output line |
| rx_i | input | 1 | Serial input line |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | One-cycle strobe for a received character |
| rx_frame_err_o | output | 1 | First stop bit sampled low |
| rx_par_err_o | output | 1 | Parity mismatch |
| rx_mpb_o | output | 1 | Received multiprocessor bit |

## Verification
The hardest situation to reach is a character whose second stop slot is low. The block's own transmitter always drives both stop bits high, so a loopback can never produce it. The bench therefore drives the receive line itself at the known bit period. It sends one character with a single high stop bit and then the next start bit at once, with two stop bits selected. Parity mismatches, framing errors and short start glitches are produced the same way. Random loopback traffic covers the format combinations.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int DATA_W  = 8;
  localparam int OS_RATE = 16;
  localparam int OS_W    = $clog2(OS_RATE);
  localparam int IDX_W   = $clog2(DATA_W);
  localparam int PRE_W   = 6;
  localparam int RATE_W  = 8;
  localparam int SYNC_N  = 2;

  typedef struct packed {
    logic [1:0] clk_sel;
    logic       mp_en;
    logic       par_odd;
    logic       par_en;
    logic       two_stop;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  typedef enum logic [2:0] {
    TX_IDLE, TX_START, TX_DATA, TX_EXTRA, TX_STOP1, TX_STOP2
  } tx_state_e;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_EXTRA, RX_STOP
  } rx_state_e;
endpackage

// File: rtl/xcvr_baud_gen.sv
module xcvr_baud_gen
  import xcvr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        sel_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  logic [PRE_W-1:0]  pre_cnt_q, pre_lim;
  logic [RATE_W-1:0] rate_cnt_q;
  logic              pre_tick;

  always_comb begin
    case (sel_i)
      2'd0:    pre_lim = '0;
      2'd1:    pre_lim = PRE_W'(3);
      2'd2:    pre_lim = PRE_W'(15);
      default: pre_lim = PRE_W'(63);
    endcase
  end

  assign pre_tick = (pre_cnt_q >= pre_lim);
  assign tick_o   = pre_tick && (rate_cnt_q >= rate_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_cnt_q  <= '0;
      rate_cnt_q <= '0;
    end else begin
      pre_cnt_q <= pre_tick ? '0 : pre_cnt_q + 1'b1;
      if (pre_tick) rate_cnt_q <= tick_o ? '0 : rate_cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/xcvr_tx.sv
module xcvr_tx
  import xcvr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              two_stop_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              mp_en_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              mpb_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              tx_o
);
  tx_state_e         state_q;
  logic [DATA_W-1:0] sh_q;
  logic [IDX_W-1:0]  idx_q;
  logic [OS_W-1:0]   os_q;
  logic              extra_q, has_extra_q, two_stop_q, line_q;
  logic              bit_end;

  assign ready_o = (state_q == TX_IDLE);
  assign tx_o    = line_q;
  assign bit_end = tick_i && (os_q == OS_W'(OS_RATE - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= TX_IDLE;
      sh_q        <= '0;
      idx_q       <= '0;
      os_q        <= '0;
      extra_q     <= 1'b0;
      has_extra_q <= 1'b0;
      two_stop_q  <= 1'b0;
      line_q      <= 1'b1;
    end else if (state_q == TX_IDLE) begin
      line_q <= 1'b1;
      if (valid_i) begin
        sh_q        <= data_i;
        extra_q     <= mp_en_i ? mpb_i : ((^data_i) ^ par_odd_i);
        has_extra_q <= mp_en_i | par_en_i;
        two_stop_q  <= two_stop_i;
        os_q        <= '0;
        idx_q       <= '0;
        line_q      <= 1'b0;
        state_q     <= TX_START;
      end
    end else if (tick_i) begin
      os_q <= os_q + 1'b1;
      if (bit_end) begin
        os_q <= '0;
        unique case (state_q)
          TX_START: begin
            line_q  <= sh_q[0];
            state_q <= TX_DATA;
          end
          TX_DATA: begin
            sh_q <= sh_q >> 1;
            if (idx_q == IDX_W'(DATA_W - 1)) begin
              line_q  <= has_extra_q ? extra_q : 1'b1;
              state_q <= has_extra_q ? TX_EXTRA : TX_STOP1;
            end else begin
              idx_q  <= idx_q + 1'b1;
              line_q <= sh_q[1];
            end
          end
          TX_EXTRA: begin
            line_q  <= 1'b1;
            state_q <= TX_STOP1;
          end
          TX_STOP1: state_q <= two_stop_q ? TX_STOP2 : TX_IDLE;
          default:  state_q <= TX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/xcvr_rx.sv
module xcvr_rx
  import xcvr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              mp_en_i,
  input  logic              rx_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              ferr_o,
  output logic              perr_o,
  output logic              mpb_o
);
  logic [SYNC_N-1:0] sync_q;
  logic              line, prev_q, fall;
  rx_state_e         state_q;
  logic [DATA_W-1:0] sh_q;
  logic [IDX_W-1:0]  idx_q;
  logic [OS_W-1:0]   os_q;
  logic              extra_q, has_extra_q, par_en_q, par_odd_q, mp_q;
  logic              mid_start, centre;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], rx_i};
      prev_q <= line;
    end
  end

  assign line      = sync_q[SYNC_N-1];
  assign fall      = prev_q & ~line;
  assign mid_start = tick_i && (os_q == OS_W'(OS_RATE / 2 - 1));
  assign centre    = tick_i && (os_q == OS_W'(OS_RATE - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= RX_IDLE;
      sh_q        <= '0;
      idx_q       <= '0;
      os_q        <= '0;
      extra_q     <= 1'b0;
      has_extra_q <= 1'b0;
      par_en_q    <= 1'b0;
      par_odd_q   <= 1'b0;
      mp_q        <= 1'b0;
      data_o      <= '0;
      valid_o     <= 1'b0;
      ferr_o      <= 1'b0;
      perr_o      <= 1'b0;
      mpb_o       <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (tick_i) os_q <= os_q + 1'b1;
      unique case (state_q)
        RX_IDLE: if (fall) begin
          os_q    <= '0;
          state_q <= RX_START;
        end
        RX_START: if (mid_start) begin
          os_q <= '0;
          if (!line) begin
            idx_q       <= '0;
            mp_q        <= mp_en_i;
            par_en_q    <= par_en_i & ~mp_en_i;
            par_odd_q   <= par_odd_i;
            has_extra_q <= mp_en_i | par_en_i;
            extra_q     <= 1'b0;
            state_q     <= RX_DATA;
          end else begin
            state_q <= RX_IDLE;
          end
        end
        RX_DATA: if (centre) begin
          sh_q  <= {line, sh_q[DATA_W-1:1]};
          idx_q <= idx_q + 1'b1;
          if (idx_q == IDX_W'(DATA_W - 1))
            state_q <= has_extra_q ? RX_EXTRA : RX_STOP;
        end
        RX_EXTRA: if (centre) begin
          extra_q <= line;
          state_q <= RX_STOP;
        end
        default: if (centre) begin
          // only first stop sampled; any low after this is a new start
          valid_o <= 1'b1;
          data_o  <= sh_q;
          ferr_o  <= ~line;
          perr_o  <= par_en_q & (extra_q != ((^sh_q) ^ par_odd_q));
          mpb_o   <= mp_q & extra_q;
          state_q <= RX_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/serial_xcvr.sv
module serial_xcvr
  import xcvr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_wdata_i,
  input  logic              rate_we_i,
  input  logic [RATE_W-1:0] rate_wdata_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_mpb_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              tx_o,
  input  logic              rx_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              rx_frame_err_o,
  output logic              rx_par_err_o,
  output logic              rx_mpb_o
);
  mode_t             mode_q;
  logic [RATE_W-1:0] rate_q;
  logic              tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      rate_q <= '0;
    end else begin
      if (mode_we_i) mode_q <= mode_t'(mode_wdata_i);
      if (rate_we_i) rate_q <= rate_wdata_i;
    end
  end

  xcvr_baud_gen u_baud (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (mode_q.clk_sel),
    .rate_i (rate_q),
    .tick_o (tick)
  );

  xcvr_tx u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .two_stop_i (mode_q.two_stop),
    .par_en_i   (mode_q.par_en),
    .par_odd_i  (mode_q.par_odd),
    .mp_en_i    (mode_q.mp_en),
    .data_i     (tx_data_i),
    .mpb_i      (tx_mpb_i),
    .valid_i    (tx_valid_i),
    .ready_o    (tx_ready_o),
    .tx_o       (tx_o)
  );

  xcvr_rx u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .par_en_i  (mode_q.par_en),
    .par_odd_i (mode_q.par_odd),
    .mp_en_i   (mode_q.mp_en),
    .rx_i      (rx_i),
    .data_o    (rx_data_o),
    .valid_o   (rx_valid_o),
    .ferr_o    (rx_frame_err_o),
    .perr_o    (rx_par_err_o),
    .mpb_o     (rx_mpb_o)
  );
endmodule

// File: rtl/serial_xcvr_chk.sv
module serial_xcvr_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_valid_i,
  input logic tx_ready_o,
  input logic tx_o,
  input logic rx_valid_o,
  input logic rx_frame_err_o,
  input logic rx_par_err_o,
  input logic mp_en_i
);
  // R2
  idle_line_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> tx_o);

  // R2
  accept_on_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_ready_o) |-> $past(tx_valid_i));

  // R4
  rx_strobe_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  // R4
  ferr_with_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rx_frame_err_o) |-> rx_valid_o);

  // R6
  perr_with_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rx_par_err_o) |-> rx_valid_o);

  // R7
  mp_no_perr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && mp_en_i) |-> !rx_par_err_o);
endmodule

bind serial_xcvr serial_xcvr_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .tx_valid_i     (tx_valid_i),
  .tx_ready_o     (tx_ready_o),
  .tx_o           (tx_o),
  .rx_valid_o     (rx_valid_o),
  .rx_frame_err_o (rx_frame_err_o),
  .rx_par_err_o   (rx_par_err_o),
  .mp_en_i        (mode_q.mp_en)
);

// File: tb/sim_serial_xcvr.sv
`timescale 1ns/1ps
module sim_serial_xcvr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_we = 1'b0, rate_we = 1'b0;
  logic [5:0] mode_wd = '0;
  logic [7:0] rate_wd = '0;
  logic [7:0] tx_data = '0;
  logic       tx_mpb = 1'b0, tx_valid = 1'b0;
  logic       tx_ready_o, tx_o, rx_valid_o, rx_frame_err_o, rx_par_err_o, rx_mpb_o;
  logic [7:0] rx_data_o;
  logic       use_bb = 1'b0, bb_line = 1'b1;
  logic       rx_line;
  int         n_chk = 0, n_err = 0;
  int         bitp = 32;

  always #10 clk = ~clk;
  assign rx_line = use_bb ? bb_line : tx_o;

  serial_xcvr u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .mode_we_i(mode_we), .mode_wdata_i(mode_wd),
    .rate_we_i(rate_we), .rate_wdata_i(rate_wd),
    .tx_data_i(tx_data), .tx_mpb_i(tx_mpb), .tx_valid_i(tx_valid),
    .tx_ready_o(tx_ready_o), .tx_o(tx_o), .rx_i(rx_line),
    .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o),
    .rx_frame_err_o(rx_frame_err_o), .rx_par_err_o(rx_par_err_o), .rx_mpb_o(rx_mpb_o)
  );

  function automatic logic par_bit(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  function automatic logic [5:0] mk_mode(input int sel, input logic mp, input logic odd,
                                         input logic pen, input logic two);
    return {2'(sel), mp, odd, pen, two};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  task automatic wr_mode(input logic [5:0] m);
    @(negedge clk); mode_wd = m; mode_we = 1'b1;
    @(negedge clk); mode_we = 1'b0;
  endtask

  task automatic wr_rate(input logic [7:0] r);
    @(negedge clk); rate_wd = r; rate_we = 1'b1;
    @(negedge clk); rate_we = 1'b0;
  endtask

  task automatic send_tx(input logic [7:0] d, input logic m);
    @(negedge clk);
    while (!tx_ready_o) @(negedge clk);
    tx_data = d; tx_mpb = m; tx_valid = 1'b1;
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic wait_rx(input int limit, output bit got, output logic [7:0] d,
                         output logic fe, output logic pe, output logic mb);
    got = 0; d = '0; fe = 0; pe = 0; mb = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (rx_valid_o) begin
        got = 1; d = rx_data_o; fe = rx_frame_err_o; pe = rx_par_err_o; mb = rx_mpb_o;
        break;
      end
    end
  endtask

  task automatic bb_bit(input logic v);
    bb_line = v;
    repeat (bitp) @(negedge clk);
  endtask

  task automatic bb_frame(input logic [7:0] d, input bit has_x, input logic xb, input logic stop_v);
    bb_bit(1'b0);
    for (int i = 0; i < 8; i++) bb_bit(d[i]);
    if (has_x) bb_bit(xb);
    bb_bit(stop_v);
  endtask

  // back-to-back frames of 0x00; interval between start edges in clocks
  task automatic frame_gap(output int gap);
    int n;
    n = 0;
    @(negedge clk);
    while (tx_o) @(negedge clk);
    while (!tx_o) begin n++; @(negedge clk); end
    while (tx_o) begin n++; @(negedge clk); end
    gap = n;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    summary();
    $finish;
  end

  initial begin
    bit got;
    logic [7:0] d;
    logic fe, pe, mb;
    int gap, len, p;
    void'($urandom(32'd20240611));

    repeat (4) @(negedge clk);
    // R1 reset state
    chk(tx_o == 1'b1, "R1 tx_o", tx_o, 1);
    chk(tx_ready_o == 1'b1, "R1 tx_ready", tx_ready_o, 1);
    chk(rx_valid_o == 1'b0, "R1 rx_valid", rx_valid_o, 0);
    chk({rx_frame_err_o, rx_par_err_o, rx_mpb_o} == 3'b000, "R1 flags",
        {rx_frame_err_o, rx_par_err_o, rx_mpb_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 / R1: default mode one stop, rate 0, P = 1
    fork
      begin send_tx(8'h00, 1'b0); send_tx(8'h00, 1'b0); end
      frame_gap(gap);
    join
    chk(gap >= 159 && gap <= 163, "R3 one-stop gap (R1 default)", gap, 160);
    repeat (400) @(negedge clk);
    wr_mode(mk_mode(0, 0, 0, 0, 1));
    fork
      begin send_tx(8'h00, 1'b0); send_tx(8'h00, 1'b0); end
      frame_gap(gap);
    join
    chk(gap >= 175 && gap <= 179, "R3 two-stop gap", gap, 176);
    repeat (400) @(negedge clk);

    // R8 prescaler taps, N = 1
    wr_rate(8'd1);
    for (int s = 0; s < 4; s++) begin
      p = (1 << (2 * s)) * 2;
      wr_mode(mk_mode(s, 0, 0, 0, 0));
      repeat (p + 2) @(negedge clk);
      len = 0;
      fork
        send_tx(8'hFF, 1'b0);
        begin
          @(negedge clk);
          while (tx_o) @(negedge clk);
          while (!tx_o) begin len++; @(negedge clk); end
        end
      join
      chk(len >= 15 * p && len <= 16 * p + 1, $sformatf("R8 start bit length tap %0d", s), len, 16 * p);
      wait_rx(12 * 16 * p, got, d, fe, pe, mb);
      chk(got && d == 8'hFF && !fe, $sformatf("R8 loopback tap %0d", s), d, 8'hFF);
    end

    // R2 R6 R7 random loopback, tap 0, N = 1
    wr_mode(mk_mode(0, 0, 0, 0, 0));
    repeat (200) @(negedge clk);
    for (int k = 0; k < 24; k++) begin
      logic [5:0] m;
      logic [7:0] dat;
      logic mpb;
      m   = mk_mode(0, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      dat = 8'($urandom);
      mpb = 1'($urandom);
      if (k == 0) dat = 8'h00;
      if (k == 1) dat = 8'hA5;
      wr_mode(m);
      send_tx(dat, mpb);
      wait_rx(1000, got, d, fe, pe, mb);
      chk(got && d == dat, "R2 loopback data", d, dat);
      chk(!fe && !pe, "R6 no error on clean frame", {fe, pe}, 0);
      chk(mb == (m[3] & mpb), "R7 mp bit", mb, m[3] & mpb);
    end
    repeat (200) @(negedge clk);

    // bench-driven line, P = 2, bit = 32 clocks
    use_bb = 1'b1;
    bitp = 32;
    repeat (40) @(negedge clk);

    // R6 even parity error and clean
    wr_mode(mk_mode(0, 0, 0, 1, 0));
    fork bb_frame(8'h5A, 1, ~par_bit(8'h5A, 0), 1'b1); wait_rx(800, got, d, fe, pe, mb); join
    chk(got && pe, "R6 even parity mismatch", pe, 1);
    bb_bit(1'b1);
    fork bb_frame(8'h5A, 1, par_bit(8'h5A, 0), 1'b1); wait_rx(800, got, d, fe, pe, mb); join
    chk(got && !pe && d == 8'h5A, "R6 even parity match", pe, 0);
    bb_bit(1'b1);
    wr_mode(mk_mode(0, 0, 1, 1, 0));
    fork bb_frame(8'h07, 1, ~par_bit(8'h07, 1), 1'b1); wait_rx(800, got, d, fe, pe, mb); join
    chk(got && pe, "R6 odd parity mismatch", pe, 1);
    bb_bit(1'b1);

    // R7 mp overrides parity
    wr_mode(mk_mode(0, 1, 0, 1, 0));
    fork bb_frame(8'h5A, 1, 1'b1, 1'b1); wait_rx(800, got, d, fe, pe, mb); join
    chk(got && !pe && mb, "R7 mp ignores parity", {pe, mb}, 1);
    bb_bit(1'b1);

    // R4 framing error on first stop, two-stop mode
    wr_mode(mk_mode(0, 0, 0, 0, 1));
    fork bb_frame(8'h3C, 0, 1'b0, 1'b0); wait_rx(800, got, d, fe, pe, mb); join
    chk(got && fe && d == 8'h3C, "R4 first stop low", fe, 1);
    bb_bit(1'b1);
    bb_bit(1'b1);

    // R5 second stop low starts next character
    fork
      begin bb_frame(8'hC3, 0, 1'b0, 1'b1); bb_frame(8'h96, 0, 1'b0, 1'b1); bb_bit(1'b1); end
      begin
        logic [7:0] d1, d2;
        logic fe1, fe2, x1, x2;
        bit g1, g2;
        wait_rx(800, g1, d1, fe1, x1, x2);
        wait_rx(800, g2, d2, fe2, x1, x2);
        chk(g1 && d1 == 8'hC3 && !fe1, "R5 first char", d1, 8'hC3);
        chk(g2 && d2 == 8'h96 && !fe2, "R5 next char from low stop2", d2, 8'h96);
      end
    join

    // R9 short glitch ignored
    wr_mode(mk_mode(0, 0, 0, 0, 0));
    bb_line = 1'b0;
    repeat (8) @(negedge clk);
    bb_line = 1'b1;
    wait_rx(600, got, d, fe, pe, mb);
    chk(!got, "R9 glitch rejected", got, 0);
    fork bb_frame(8'h81, 0, 1'b0, 1'b1); wait_rx(800, got, d, fe, pe, mb); join
    chk(got && d == 8'h81, "R9 frame after glitch", d, 8'h81);

    summary();
    $finish;
  end
endmodule